// File: doc/BRIEF.md
# Presettable Decade/Binary Synchronous Counter

A four-bit counter that moves on the rising clock edge. It can be preset from a parallel data word, and it can be chained into multi-digit counters. Two build-time parameters choose the variant. `DECADE` picks BCD modulo-10 counting or plain modulo-16 counting. `ASYNC_CLR` decides whether the active-low clear acts at once or waits for the next rising edge.

Counting needs two enables to be high at the same time. The parallel enable `en_p` is meant to be shared by every stage of a chain. The trickle enable `en_t` is meant to carry the carry from the stage below. The terminal-count flag `tc` is combinational. It is high only when `en_t` is high and the count is at its top value, so wiring each `tc` to the next stage's `en_t` gives a synchronous multi-digit counter. In decade mode a preset may load any value from 10 to 15. Counting then steers it back into the legal sequence.

Every port is a plain control or status pin, with no handshake. The count is state, not a stream, so the block has no valid/ready interface and no back-pressure rules.

Top module: `psync_counter`

## Requirements
- R1: With `DECADE=0`, a count step moves `q` to `q+1` modulo 16, so 15 is followed by 0.
- R2: With `DECADE=1`, a count step from states 0 to 8 moves `q` to `q+1`, and state 9 is followed by 0. Counting from a legal state never leaves the range 0 to 9.
- R3: With `ASYNC_CLR=1`, driving `clr_n` low forces `q` to 0 at once, with no clock edge. `q` stays 0 while `clr_n` is low, whatever the other inputs do.
- R4: With `ASYNC_CLR=0`, `clr_n` low has no effect on `q` until the next rising edge. On that edge `q` becomes 0, even when a load or a count is also requested.
- R5: On a rising edge with `clr_n` high and `ld_n` low, `q` takes the value of `d`. This happens whatever the enables are, and any 4-bit value may be loaded in either mode.
- R6: On a rising edge with `clr_n` and `ld_n` high, `q` advances only when `en_p` and `en_t` are both 1. Otherwise `q` keeps its value.
- R7: `tc` is 1 exactly when `en_t` is 1 and `q` is at its top value: 9 (binary 1001) in decade mode, or 15 in binary mode. It follows `en_t` and `q` with no clock and is unaffected by `en_p`.
- R8: In decade mode a count step sends the illegal states 10, 12 and 14 to 11, 13 and 15, and sends 11, 13 and 15 to 6, 4 and 2. Any illegal state therefore reaches 0 to 9 within two count steps.
- R9: Three stages chain into a synchronous counter. All `en_p` are tied high, the first `en_t` is the chain enable, and each later `en_t` is the `tc` of the stage below. Such a chain counts modulo 1000 in decade mode and modulo 4096 in binary mode, one step per enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or edge-sampled depending on `ASYNC_CLR` |
| ld_n | input | 1 | Active-low parallel load |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Trickle count enable; also gates `tc` |
| d | input | WIDTH | Parallel preset data |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal count, for cascading |

## Verification
The hardest states to reach are the decade illegal values 10 to 15. Counting from 0 never reaches them; only a preset can put them in the register. The bench loads every one of the 16 values into both variants and then applies each combination of load and the two enables. For the pure-count combination it takes a second step, so the two-edge return into 0 to 9 is observed. The clear timing is also tested: clear is dropped one nanosecond after an edge and `q` is sampled before the next edge, which separates the immediate variant from the edge-sampled one.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

  // Action the state register takes on the coming rising edge
  typedef enum logic [1:0] {
    ACT_CLEAR = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_STEP  = 2'd2,
    ACT_HOLD  = 2'd3
  } pcnt_act_e;

  // Highest state of a counter of the given width and modulus
  function automatic int unsigned top_value(input int unsigned width, input bit decade);
    if (decade) return 9;
    return (1 << width) - 1;
  endfunction

endpackage

// File: rtl/pcnt_mode_sel.sv
module pcnt_mode_sel
  import pcnt_pkg::*;
(
  input  logic      clr_n,
  input  logic      ld_n,
  input  logic      en_p,
  input  logic      en_t,
  output pcnt_act_e act
);

  // Priority: clear, then load, then count, else hold
  always_comb begin
    if (!clr_n)               act = ACT_CLEAR;
    else if (!ld_n)           act = ACT_LOAD;
    else if (en_p && en_t)    act = ACT_STEP;
    else                      act = ACT_HOLD;
  end

endmodule

// File: rtl/pcnt_next.sv
module pcnt_next
  import pcnt_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  input  pcnt_act_e        act,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(top_value(WIDTH, DECADE));

  logic [WIDTH-1:0] stepped;

  generate
    if (DECADE) begin : g_bcd
      // Legal states wrap at 9; illegal states are steered back
      always_comb begin
        if (cur == TOP)            stepped = '0;
        else if (cur < TOP)        stepped = cur + 1'b1;
        else begin
          case (cur)
            WIDTH'(11): stepped = WIDTH'(6);
            WIDTH'(13): stepped = WIDTH'(4);
            WIDTH'(15): stepped = WIDTH'(2);
            default:    stepped = cur + 1'b1;
          endcase
        end
      end
    end else begin : g_bin
      // Natural wrap of the WIDTH-bit adder
      always_comb stepped = cur + 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = din;
      ACT_STEP:  nxt = stepped;
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/pcnt_term.sv
module pcnt_term
  import pcnt_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_t,
  output logic             tc
);

  localparam logic [WIDTH-1:0] TOP = WIDTH'(top_value(WIDTH, DECADE));

  // Combinational so a chain carries within the same cycle
  assign tc = en_t && (cur == TOP);

endmodule

// File: rtl/psync_counter.sv
module psync_counter
  import pcnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          DECADE    = 1'b1,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             tc
);

  pcnt_act_e        act;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  pcnt_mode_sel u_sel (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .act   (act)
  );

  pcnt_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
    .cur (cnt_q),
    .din (d),
    .act (act),
    .nxt (cnt_d)
  );

  pcnt_term #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
    .cur  (cnt_q),
    .en_t (en_t),
    .tc   (tc)
  );

  generate
    if (ASYNC_CLR) begin : g_aclr
      // Clear reaches the flops without waiting for the clock
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end else begin : g_sclr
      // Clear is part of the next-state decode and waits for an edge
      always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
      end
    end
  endgenerate

  assign q = cnt_q;

endmodule

// File: rtl/pcnt_chk.sv
module pcnt_chk #(
  parameter int unsigned WIDTH     = 4,
  parameter bit          DECADE    = 1'b1,
  parameter bit          ASYNC_CLR = 1'b1
) (
  input logic             clk,
  input logic             clr_n,
  input logic             ld_n,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q,
  input logic             tc
);

  localparam logic [WIDTH-1:0] TOPV = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  logic step_req;
  assign step_req = clr_n && ld_n && en_p && en_t;

  // R5
  load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> q == $past(d));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_p && en_t)) |=> $stable(q));

  // R7
  tc_needs_t_chk: assert property (@(posedge clk) tc |-> (en_t && q == TOPV));

  // R7
  tc_off_chk: assert property (@(posedge clk) !en_t |-> !tc);

  generate
    if (DECADE) begin : g_dec_chk
      // R2
      dec_inc_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (step_req && q < TOPV) |=> q == $past(q) + 1'b1);
      // R2
      dec_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (step_req && q == TOPV) |=> q == '0);
      // R8
      dec_recover_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (step_req && q > TOPV) ##1 step_req |=> q <= TOPV);
    end else begin : g_bin_chk
      // R1
      bin_inc_chk: assert property (@(posedge clk) disable iff (!clr_n)
        step_req |=> q == WIDTH'($past(q) + 1'b1));
    end

    if (ASYNC_CLR) begin : g_aclr_chk
      // R3
      aclr_hold_chk: assert property (@(posedge clk) !clr_n |-> q == '0);
    end else begin : g_sclr_chk
      // R4
      sclr_edge_chk: assert property (@(posedge clk) !clr_n |=> q == '0);
    end
  endgenerate

endmodule

bind psync_counter pcnt_chk #(
  .WIDTH     (WIDTH),
  .DECADE    (DECADE),
  .ASYNC_CLR (ASYNC_CLR)
) u_chk (
  .clk   (clk),
  .clr_n (clr_n),
  .ld_n  (ld_n),
  .en_p  (en_p),
  .en_t  (en_t),
  .d     (d),
  .q     (q),
  .tc    (tc)
);

// File: tb/psync_counter_tb.sv
`timescale 1ns/1ps
module psync_counter_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int nvec = 0;
  int nbad = 0;

  // Shared stimulus for the two single stages
  logic       clr_n = 1'b0, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] d = 4'd0;
  logic [3:0] q_dec, q_bin;
  logic       tc_dec, tc_bin;

  // u_dut: decade, immediate clear; u_bin: binary, edge clear
  psync_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
    .d(d), .q(q_dec), .tc(tc_dec));

  psync_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_bin (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
    .d(d), .q(q_bin), .tc(tc_bin));

  // Three-stage chains (R9)
  logic       ch_clr_n = 1'b0, cen = 1'b0;
  logic [2:0] et_d, et_b, tc_d, tc_b;
  logic [3:0] cq_d [3];
  logic [3:0] cq_b [3];

  assign et_d = {tc_d[1:0], cen};
  assign et_b = {tc_b[1:0], cen};

  for (genvar k = 0; k < 3; k++) begin : g_chain
    psync_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_dst (
      .clk(clk), .clr_n(ch_clr_n), .ld_n(1'b1), .en_p(1'b1), .en_t(et_d[k]),
      .d(4'd0), .q(cq_d[k]), .tc(tc_d[k]));
    psync_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_bst (
      .clk(clk), .clr_n(ch_clr_n), .ld_n(1'b1), .en_p(1'b1), .en_t(et_b[k]),
      .d(4'd0), .q(cq_b[k]), .tc(tc_b[k]));
  end

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Independent reference: next value for one stage
  function automatic logic [3:0] model(input bit dec, input logic [3:0] cur,
                                       input bit ldn, input bit ep, input bit et,
                                       input logic [3:0] dd);
    if (!ldn) return dd;
    if (!(ep && et)) return cur;
    if (!dec) return cur + 4'd1;
    if (cur == 4'd9) return 4'd0;
    if (cur < 4'd9 || !cur[0]) return cur + 4'd1;
    return 4'(5'd17 - {1'b0, cur});
  endfunction

  initial begin : watchdog
    #(5.0 * 150000);
    nbad++;
    nvec++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin : stim
    logic [3:0] ed, eb;
    int rd, rb;
    tick();
    tick();
    // R3 R4: both cleared after reset edges
    chk("R3 reset", q_dec, 0);
    chk("R4 reset", q_bin, 0);
    clr_n = 1'b1;

    // Sweep every state against every load/enable combination
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 8; c++) begin
        ld_n = 1'b0; d = 4'(s); en_p = 1'b0; en_t = 1'b0;
        tick();
        chk("R5 preset dec", q_dec, s);
        chk("R5 preset bin", q_bin, s);
        ld_n = c[2]; en_p = c[1]; en_t = c[0]; d = ~4'(s);
        #1;
        // R7: combinational flag, en_p plays no part
        chk("R7 tc dec", tc_dec, int'(c[0] && s == 9));
        chk("R7 tc bin", tc_bin, int'(c[0] && s == 15));
        ed = model(1'b1, 4'(s), c[2], c[1], c[0], ~4'(s));
        eb = model(1'b0, 4'(s), c[2], c[1], c[0], ~4'(s));
        tick();
        // R1 R2 R5 R6 R8
        chk(c == 7 ? (s > 9 ? "R8 dec step" : "R2 dec step")
                   : (c[2] ? "R6 dec hold" : "R5 dec load"), q_dec, ed);
        chk(c == 7 ? "R1 bin step" : (c[2] ? "R6 bin hold" : "R5 bin load"), q_bin, eb);
        if (c == 7) begin
          ed = model(1'b1, ed, 1'b1, 1'b1, 1'b1, 4'd0);
          eb = model(1'b0, eb, 1'b1, 1'b1, 1'b1, 4'd0);
          tick();
          chk("R8 dec second step", q_dec, ed);
          chk("R8 dec legal after two", int'(q_dec <= 4'd9), 1);
          chk("R1 bin second step", q_bin, eb);
        end
      end
    end

    // Clear timing: drop clear between edges with load and count requested
    ld_n = 1'b0; d = 4'd5; en_p = 1'b1; en_t = 1'b1;
    tick();
    chk("R5 preset 5", q_dec, 5);
    clr_n = 1'b0;
    #1;
    chk("R3 immediate clear", q_dec, 0);
    chk("R4 waits for edge", q_bin, 5);
    tick();
    chk("R3 held by clear", q_dec, 0);
    chk("R4 clear beats load", q_bin, 0);
    clr_n = 1'b1; ld_n = 1'b1;
    tick();
    chk("R2 count after clear", q_dec, 1);
    chk("R1 count after clear", q_bin, 1);
    en_p = 1'b0; en_t = 1'b0;

    // Chains
    tick();
    chk("R9 dec chain cleared", cq_d[0] + 10 * cq_d[1] + 100 * cq_d[2], 0);
    chk("R9 bin chain cleared", cq_b[0] + 16 * cq_b[1] + 256 * cq_b[2], 0);
    ch_clr_n = 1'b1;
    rd = 0; rb = 0;
    for (int i = 0; i < 4300; i++) begin
      cen = (i % 7) != 3;
      #1;
      chk("R9 dec chain tc", tc_d[2], int'(cen && rd == 999));
      chk("R9 bin chain tc", tc_b[2], int'(cen && rb == 4095));
      tick();
      if (cen) begin
        rd = (rd + 1) % 1000;
        rb = (rb + 1) % 4096;
      end
      chk("R9 dec chain value", cq_d[0] + 10 * cq_d[1] + 100 * cq_d[2], rd);
      chk("R9 bin chain value", cq_b[0] + 16 * cq_b[1] + 256 * cq_b[2], rb);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule